// File: doc/BRIEF.md
# Programmable-Timing Asynchronous NOR Flash Controller

This block connects a simple host request port to an asynchronous NOR flash or static memory device. The device has a 16-bit data bus and a 25-bit halfword address. The host asks for a single read, a four-beat page read or a write, and supplies an address, write data and byte enables.

The controller then drives the device strobes: chip select, address-valid, output enable and write enable. It also drives the byte enables, the address and the bidirectional data bus. Each strobe edge falls on a reference-clock boundary. Its position is worked out from a set of wait-state fields:

- read wait
- page wait
- write wait
- write-enable length
- address-valid hold
- output-enable setup
- output-enable hold
- turnaround wait

All edges are measured in whole clock periods from the fall of chip select. The timing fields are sampled when a request is accepted and held for the whole access, so software may rewrite them while a transfer is in flight. Each captured read halfword is returned with a one-cycle valid pulse. A one-cycle done pulse marks the end of the bus turnaround. In that same cycle the controller is ready for the next request.

Top module: `nor_timing_ctrl`

## Requirements
- R1: A single read (`req_kind` = 2'b00) holds `mem_cs_n` low for exactly rd_wait+2 clock cycles, starting the cycle after the request is accepted.
- R2: `mem_adv_n` is low from the first chip-select-low cycle for adv_hold+1 cycles, then high; if the access is shorter it stays low until chip select rises.
- R3: During a single read, `mem_oe_n` is low from cycle s to cycle f−1, counted from the first chip-select-low cycle (cycle 0). Here h = min(oe_hold, rd_wait), f = rd_wait−h+2, and s = min(oe_setup, f−1). Output enable is never low while chip select is high.
- R4: Read data on `mem_data` is captured at the clock edge that ends the last output-enable-low cycle. It appears on `rsp_rdata` with `rsp_valid` high for one cycle, in the cycle that follows that edge.
- R5: A page read (`req_kind` = 2'b01) keeps `mem_cs_n` low for four beats. Beat 0 lasts rd_wait+2 cycles and beats 1 to 3 last page_wait+1 cycles each. The address low two bits are the request's low two bits plus the beat number, modulo 4, and the upper bits are held. `mem_oe_n` is low from cycle s until chip select rises. Data is captured on the last cycle of each beat, with one `rsp_valid` pulse per beat.
- R6: A write (`req_kind` = 2'b10 or 2'b11) holds `mem_cs_n` low for wr_wait+we_len+3 cycles. `mem_we_n` falls wr_wait+1 cycles after chip select falls, stays low for we_len+1 cycles, and rises one cycle before chip select rises. `mem_oe_n` stays high.
- R7: After chip select rises it stays high for turn_wait+1 cycles. In the next cycle `rsp_done` is high for exactly one cycle and `req_ready` is high. A request accepted in that cycle drives chip select low in the following cycle.
- R8: `mem_be_n` equals the inverted `req_be` (bit 0 is the low byte, active low at the pin) while chip select is low, and is 2'b11 otherwise. The address is held for the whole chip-select-low time of a single read or write.
- R9: `mem_data` is driven by the controller with the request's write data only while a write holds chip select low. It is released at all other times, so a read returns the device's value.
- R10: The timing fields are sampled when a request is accepted. Changing any field during an access does not alter that access's strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all strobe edges are on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a valid request is taken this cycle |
| req_kind | input | 2 | 00 single read, 01 page read, 1x write |
| req_addr | input | 25 | Halfword address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high, bit 0 is the low byte |
| cfg_rd_wait | input | 4 | Read wait field |
| cfg_page_wait | input | 4 | Page-beat wait field |
| cfg_wr_wait | input | 4 | Write wait before write enable falls |
| cfg_we_len | input | 4 | Write-enable pulse length field |
| cfg_adv_hold | input | 4 | Address-valid hold field |
| cfg_oe_setup | input | 4 | Output-enable setup field |
| cfg_oe_hold | input | 4 | Output-enable hold field |
| cfg_turn_wait | input | 4 | Bus turnaround field |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_rdata` holds a captured halfword |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-cycle pulse after the turnaround ends |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_addr | output | 25 | Halfword address to the device |
| mem_data | inout | 16 | Bidirectional data bus |

## Verification
The bench sweeps read wait, output-enable hold and setup over a small range. This includes hold values larger than the read wait, where a design without the clamp would place the output-enable rise before its fall, or wrap it around to a huge count. A zero hold makes output enable rise together with chip select, which pushes the data-valid pulse into the turnaround window; an off-by-one there shows up as a missing or early pulse. Page reads start at addresses whose low bits wrap within the page, so a controller that carried into bit 2 would present the wrong address and return the wrong data. Every access inverts all timing fields just after acceptance, so a controller that read the live fields would stretch or shorten its strobes.

// File: rtl/nor_ctrl_pkg.sv
package nor_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PAGE,
        ST_WRITE,
        ST_TURN
    } seq_state_e;

    localparam logic [1:0] KIND_READ = 2'b00;
    localparam logic [1:0] KIND_PAGE = 2'b01;

endpackage

// File: rtl/nor_timing_calc.sv
module nor_timing_calc #(
    parameter int FW = 4,
    parameter int CW = FW + 3
) (
    input  logic [FW-1:0] rd_wait,
    input  logic [FW-1:0] page_wait,
    input  logic [FW-1:0] wr_wait,
    input  logic [FW-1:0] we_len,
    input  logic [FW-1:0] adv_hold,
    input  logic [FW-1:0] oe_setup,
    input  logic [FW-1:0] oe_hold,
    input  logic [FW-1:0] turn_wait,
    output logic [CW-1:0] t_rd_len,
    output logic [CW-1:0] t_adv_len,
    output logic [CW-1:0] t_oe_on,
    output logic [CW-1:0] t_oe_off,
    output logic [CW-1:0] t_pg_len,
    output logic [CW-1:0] t_we_on,
    output logic [CW-1:0] t_we_off,
    output logic [CW-1:0] t_wr_len,
    output logic [CW-1:0] t_bt_len
);

    logic [CW-1:0] rd_x, oeh_x, oeh_eff, oes_x, oes_lim;

    always_comb begin
        rd_x     = CW'(rd_wait);
        oeh_x    = CW'(oe_hold);
        oes_x    = CW'(oe_setup);
        // hold cannot exceed read wait: keeps the release after the fall
        oeh_eff  = (oeh_x > rd_x) ? rd_x : oeh_x;
        t_rd_len = rd_x + CW'(2);
        t_oe_off = rd_x - oeh_eff + CW'(2);
        oes_lim  = t_oe_off - CW'(1);
        t_oe_on  = (oes_x > oes_lim) ? oes_lim : oes_x;
        t_adv_len = CW'(adv_hold) + CW'(1);
        t_pg_len  = CW'(page_wait) + CW'(1);
        t_we_on   = CW'(wr_wait) + CW'(1);
        t_we_off  = CW'(wr_wait) + CW'(we_len) + CW'(2);
        t_wr_len  = CW'(wr_wait) + CW'(we_len) + CW'(3);
        t_bt_len  = CW'(turn_wait) + CW'(1);
    end

endmodule

// File: rtl/nor_data_io.sv
module nor_data_io #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] dout,
    input  logic          dout_en,
    output logic [DW-1:0] din,
    inout  wire  [DW-1:0] pad
);

    assign pad = dout_en ? dout : {DW{1'bz}};
    assign din = pad;

endmodule

// File: rtl/nor_seq.sv
module nor_seq
    import nor_ctrl_pkg::*;
#(
    parameter int AW    = 25,
    parameter int DW    = 16,
    parameter int BW    = 2,
    parameter int CW    = 7,
    parameter int BEATS = 4,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    input  logic [CW-1:0] t_rd_len,
    input  logic [CW-1:0] t_adv_len,
    input  logic [CW-1:0] t_oe_on,
    input  logic [CW-1:0] t_oe_off,
    input  logic [CW-1:0] t_pg_len,
    input  logic [CW-1:0] t_we_on,
    input  logic [CW-1:0] t_we_off,
    input  logic [CW-1:0] t_wr_len,
    input  logic [CW-1:0] t_bt_len,
    input  logic [DW-1:0] din,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          cs_n,
    output logic          adv_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [BW-1:0] be_n,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     bcnt;
        logic [BEAT_W-1:0] beat;
        logic [CW-1:0]     rd_len;
        logic [CW-1:0]     adv_len;
        logic [CW-1:0]     oe_on;
        logic [CW-1:0]     oe_off;
        logic [CW-1:0]     pg_len;
        logic [CW-1:0]     we_on;
        logic [CW-1:0]     we_off;
        logic [CW-1:0]     wr_len;
        logic [CW-1:0]     bt_len;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic [BW-1:0]     be;
        logic [DW-1:0]     rdata;
        logic              rvalid;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [CW-1:0] beat_len;
    logic          access;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.done   = 1'b0;
        beat_len   = (r_q.beat == '0) ? r_q.rd_len : r_q.pg_len;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.cnt     = '0;
                    r_d.bcnt    = '0;
                    r_d.beat    = '0;
                    r_d.rd_len  = t_rd_len;
                    r_d.adv_len = t_adv_len;
                    r_d.oe_on   = t_oe_on;
                    r_d.oe_off  = t_oe_off;
                    r_d.pg_len  = t_pg_len;
                    r_d.we_on   = t_we_on;
                    r_d.we_off  = t_we_off;
                    r_d.wr_len  = t_wr_len;
                    r_d.bt_len  = t_bt_len;
                    r_d.addr    = req_addr;
                    r_d.wdata   = req_wdata;
                    r_d.be      = req_be;
                    if (req_kind == KIND_READ)      r_d.st = ST_READ;
                    else if (req_kind == KIND_PAGE) r_d.st = ST_PAGE;
                    else                            r_d.st = ST_WRITE;
                end
            end
            ST_READ: begin
                r_d.cnt = r_q.cnt + ONE;
                if (r_q.cnt == r_q.oe_off - ONE) begin
                    r_d.rdata  = din;
                    r_d.rvalid = 1'b1;
                end
                if (r_q.cnt == r_q.rd_len - ONE) begin
                    r_d.st   = ST_TURN;
                    r_d.bcnt = '0;
                end
            end
            ST_PAGE: begin
                r_d.cnt  = r_q.cnt + ONE;
                r_d.bcnt = r_q.bcnt + ONE;
                if (r_q.bcnt == beat_len - ONE) begin
                    r_d.rdata  = din;
                    r_d.rvalid = 1'b1;
                    r_d.bcnt   = '0;
                    if (r_q.beat == BEAT_W'(BEATS - 1)) r_d.st = ST_TURN;
                    else                                r_d.beat = r_q.beat + 1'b1;
                end
            end
            ST_WRITE: begin
                r_d.cnt = r_q.cnt + ONE;
                if (r_q.cnt == r_q.wr_len - ONE) begin
                    r_d.st   = ST_TURN;
                    r_d.bcnt = '0;
                end
            end
            ST_TURN: begin
                r_d.bcnt = r_q.bcnt + ONE;
                if (r_q.bcnt == r_q.bt_len - ONE) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // strobe decode from the registered phase counter
    always_comb begin
        access    = (r_q.st == ST_READ) || (r_q.st == ST_PAGE) || (r_q.st == ST_WRITE);
        cs_n      = !access;
        adv_n     = !(access && (r_q.cnt < r_q.adv_len));
        oe_n      = 1'b1;
        if (r_q.st == ST_READ)
            oe_n = !((r_q.cnt >= r_q.oe_on) && (r_q.cnt < r_q.oe_off));
        else if (r_q.st == ST_PAGE)
            oe_n = !(r_q.cnt >= r_q.oe_on);
        we_n      = !((r_q.st == ST_WRITE) && (r_q.cnt >= r_q.we_on) && (r_q.cnt < r_q.we_off));
        be_n      = access ? ~r_q.be : {BW{1'b1}};
        addr      = r_q.addr;
        if (r_q.st == ST_PAGE)
            addr[BEAT_W-1:0] = r_q.addr[BEAT_W-1:0] + r_q.beat;
        dout      = r_q.wdata;
        dout_en   = (r_q.st == ST_WRITE);
        req_ready = (r_q.st == ST_IDLE);
        rsp_valid = r_q.rvalid;
        rsp_rdata = r_q.rdata;
        rsp_done  = r_q.done;
    end

    a_r6_we_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);
    a_r6_we_rise_before_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !cs_n);
    a_r3_oe_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !cs_n);
    a_r3_oe_order: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |-> (r_q.oe_on < r_q.oe_off));
    a_r9_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> oe_n);
    a_r7_turn_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TURN) |-> cs_n);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r4_capture_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> !$past(oe_n));
    a_r8_be_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (be_n == {BW{1'b1}}));

endmodule

// File: rtl/nor_timing_ctrl.sv
module nor_timing_ctrl #(
    parameter int AW    = 25,
    parameter int DW    = 16,
    parameter int BW    = 2,
    parameter int FW    = 4,
    parameter int BEATS = 4,
    localparam int CW   = FW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    input  logic [FW-1:0] cfg_rd_wait,
    input  logic [FW-1:0] cfg_page_wait,
    input  logic [FW-1:0] cfg_wr_wait,
    input  logic [FW-1:0] cfg_we_len,
    input  logic [FW-1:0] cfg_adv_hold,
    input  logic [FW-1:0] cfg_oe_setup,
    input  logic [FW-1:0] cfg_oe_hold,
    input  logic [FW-1:0] cfg_turn_wait,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          mem_cs_n,
    output logic          mem_adv_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [BW-1:0] mem_be_n,
    output logic [AW-1:0] mem_addr,
    inout  wire  [DW-1:0] mem_data
);

    logic [CW-1:0] t_rd_len, t_adv_len, t_oe_on, t_oe_off, t_pg_len;
    logic [CW-1:0] t_we_on, t_we_off, t_wr_len, t_bt_len;
    logic [DW-1:0] din, dout;
    logic          dout_en;

    nor_timing_calc #(.FW(FW), .CW(CW)) i_calc (
        .rd_wait   (cfg_rd_wait),
        .page_wait (cfg_page_wait),
        .wr_wait   (cfg_wr_wait),
        .we_len    (cfg_we_len),
        .adv_hold  (cfg_adv_hold),
        .oe_setup  (cfg_oe_setup),
        .oe_hold   (cfg_oe_hold),
        .turn_wait (cfg_turn_wait),
        .t_rd_len  (t_rd_len),
        .t_adv_len (t_adv_len),
        .t_oe_on   (t_oe_on),
        .t_oe_off  (t_oe_off),
        .t_pg_len  (t_pg_len),
        .t_we_on   (t_we_on),
        .t_we_off  (t_we_off),
        .t_wr_len  (t_wr_len),
        .t_bt_len  (t_bt_len)
    );

    nor_seq #(.AW(AW), .DW(DW), .BW(BW), .CW(CW), .BEATS(BEATS)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .t_rd_len  (t_rd_len),
        .t_adv_len (t_adv_len),
        .t_oe_on   (t_oe_on),
        .t_oe_off  (t_oe_off),
        .t_pg_len  (t_pg_len),
        .t_we_on   (t_we_on),
        .t_we_off  (t_we_off),
        .t_wr_len  (t_wr_len),
        .t_bt_len  (t_bt_len),
        .din       (din),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_done  (rsp_done),
        .cs_n      (mem_cs_n),
        .adv_n     (mem_adv_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .be_n      (mem_be_n),
        .addr      (mem_addr),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    nor_data_io #(.DW(DW)) i_io (
        .dout    (dout),
        .dout_en (dout_en),
        .din     (din),
        .pad     (mem_data)
    );

endmodule

// File: tb/test_nor_timing_ctrl.sv
module test_nor_timing_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [3:0]  c_rd = '0, c_pg = '0, c_wr = '0, c_wl = '0;
    logic [3:0]  c_adv = '0, c_oes = '0, c_oeh = '0, c_bt = '0;
    logic        rsp_valid, rsp_done;
    logic [15:0] rsp_rdata;
    logic        cs_n, adv_n, oe_n, we_n;
    logic [1:0]  be_n;
    logic [24:0] m_addr;
    wire  [15:0] m_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // device model: drives a value derived from the address while OE is low
    assign m_data = (!oe_n) ? (m_addr[15:0] ^ 16'h5A3C) : 16'hzzzz;

    nor_timing_ctrl i_nor_timing_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .cfg_rd_wait(c_rd), .cfg_page_wait(c_pg), .cfg_wr_wait(c_wr),
        .cfg_we_len(c_wl), .cfg_adv_hold(c_adv), .cfg_oe_setup(c_oes),
        .cfg_oe_hold(c_oeh), .cfg_turn_wait(c_bt),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .mem_cs_n(cs_n), .mem_adv_n(adv_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_be_n(be_n), .mem_addr(m_addr), .mem_data(m_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int rd, input int pg, input int wr, input int wl,
                           input int adv, input int oes, input int oeh, input int bt);
        c_rd = 4'(rd); c_pg = 4'(pg); c_wr = 4'(wr); c_wl = 4'(wl);
        c_adv = 4'(adv); c_oes = 4'(oes); c_oeh = 4'(oeh); c_bt = 4'(bt);
    endtask

    task automatic run_acc(input logic [1:0] kind, input logic [24:0] a,
                           input logic [15:0] wd, input logic [1:0] be);
        int rd, pg, wr, wl, adv, oes, oeh, bt;
        int h, f, s, cs_len, last;
        int e_cs, e_adv, e_oe, e_we, e_be, e_addr, e_data, e_rv, e_rd, e_turn;
        int rv_cnt, rv_exp;
        logic [3:0] sv [8];
        bit is_rd, is_pg, is_wr;
        rd = c_rd; pg = c_pg; wr = c_wr; wl = c_wl;
        adv = c_adv; oes = c_oes; oeh = c_oeh; bt = c_bt;
        sv[0] = c_rd; sv[1] = c_pg; sv[2] = c_wr; sv[3] = c_wl;
        sv[4] = c_adv; sv[5] = c_oes; sv[6] = c_oeh; sv[7] = c_bt;
        is_rd = (kind == 2'b00);
        is_pg = (kind == 2'b01);
        is_wr = kind[1];
        h = (oeh > rd) ? rd : oeh;
        f = rd - h + 2;
        s = (oes > f - 1) ? f - 1 : oes;
        if (is_rd)      cs_len = rd + 2;
        else if (is_pg) cs_len = rd + 2 + 3 * (pg + 1);
        else            cs_len = wr + wl + 3;
        last = cs_len + bt + 1;
        rv_exp = is_rd ? 1 : (is_pg ? 4 : 0);
        chk("R7 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        // R10: disturb every field right after acceptance
        c_rd = ~c_rd; c_pg = ~c_pg; c_wr = ~c_wr; c_wl = ~c_wl;
        c_adv = ~c_adv; c_oes = ~c_oes; c_oeh = ~c_oeh; c_bt = ~c_bt;
        e_cs = 0; e_adv = 0; e_oe = 0; e_we = 0; e_be = 0; e_addr = 0;
        e_data = 0; e_rv = 0; e_rd = 0; e_turn = 0; rv_cnt = 0;
        for (int k = 0; k <= last; k++) begin
            bit in_cs, x_oe, x_we, x_rv;
            int beat, bstart;
            logic [24:0] x_addr, rv_addr;
            in_cs = (k < cs_len);
            beat = 0; bstart = 0;
            if (is_pg && in_cs && k >= rd + 2) begin
                beat = 1 + (k - (rd + 2)) / (pg + 1);
            end
            x_addr = a;
            if (is_pg) x_addr[1:0] = a[1:0] + 2'(beat);
            x_oe = 1'b0; x_we = 1'b0; x_rv = 1'b0; rv_addr = a;
            if (in_cs) begin
                if (is_rd) x_oe = (k >= s) && (k < f);
                if (is_pg) x_oe = (k >= s);
                if (is_wr) x_we = (k >= wr + 1) && (k < wr + wl + 2);
            end
            if (is_rd && k == f) x_rv = 1'b1;
            if (is_pg) begin
                for (int b = 0; b < 4; b++) begin
                    if (k == rd + 2 + b * (pg + 1)) begin
                        x_rv = 1'b1;
                        rv_addr[1:0] = a[1:0] + 2'(b);
                    end
                end
            end
            if (cs_n != !in_cs) e_cs++;
            if (adv_n != !(in_cs && k < adv + 1)) e_adv++;
            if (oe_n != !x_oe) e_oe++;
            if (we_n != !x_we) e_we++;
            if (be_n != (in_cs ? ~be : 2'b11)) e_be++;
            if (in_cs && m_addr != x_addr) e_addr++;
            if (in_cs && is_wr && m_data != wd) e_data++;
            if (rsp_valid != x_rv) e_rv++;
            if (rsp_valid) begin
                rv_cnt++;
                if (rsp_rdata != (rv_addr[15:0] ^ 16'h5A3C)) e_rd++;
            end
            if (rsp_done != (k == last)) e_turn++;
            if (k == last && !req_ready) e_turn++;
            if (k < last) @(negedge clk);
        end
        c_rd = sv[0]; c_pg = sv[1]; c_wr = sv[2]; c_wl = sv[3];
        c_adv = sv[4]; c_oes = sv[5]; c_oeh = sv[6]; c_bt = sv[7];
        if (is_rd) chk("R1 read chip-select window", e_cs, 0);
        if (is_pg) chk("R5 page chip-select window", e_cs, 0);
        if (is_wr) chk("R6 write chip-select window", e_cs, 0);
        chk("R2 address-valid window", e_adv, 0);
        chk("R3 output-enable window", e_oe, 0);
        chk("R6 write-enable window", e_we, 0);
        chk("R8 byte enables", e_be, 0);
        if (is_pg) chk("R5 page address", e_addr, 0);
        else       chk("R8 address hold", e_addr, 0);
        if (is_wr) chk("R9 write data driven", e_data, 0);
        chk("R4 data-valid timing", e_rv, 0);
        chk("R4 data-valid count", rv_cnt, rv_exp);
        if (is_rd) chk("R9 read data from device", e_rd, 0);
        if (is_pg) chk("R5 page data", e_rd, 0);
        chk("R7 turnaround and done", e_turn, 0);
        if (kind == 2'b11) chk("R6 kind 11 is write", e_we + e_cs, 0);
        chk("R10 fields held while disturbed", e_cs + e_oe + e_we + e_adv, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset cs_n", int'(cs_n), 1);
        chk("R8 reset be_n", int'(be_n), 3);
        chk("R3 reset oe_n", int'(oe_n), 1);
        chk("R6 reset we_n", int'(we_n), 1);
        chk("R2 reset adv_n", int'(adv_n), 1);
        chk("R7 reset done", int'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 ready after reset", int'(req_ready), 1);
        // single reads: sweep read wait, OE hold (incl. above read wait), OE setup
        for (int rd = 0; rd < 4; rd++)
            for (int oeh = 0; oeh < 5; oeh++)
                for (int oes = 0; oes < 4; oes++) begin
                    set_cfg(rd, 1, 0, 0, (rd + oes) % 4, oes, oeh, oeh % 3);
                    run_acc(2'b00, 25'(rd * 977 + oeh * 31 + oes), 16'h0, 2'(oes));
                end
        // page reads: wrap of the low two address bits
        for (int rd = 0; rd < 3; rd++)
            for (int pg = 0; pg < 4; pg++)
                for (int adv = 0; adv < 2; adv++) begin
                    set_cfg(rd, pg, 0, 0, adv * 5, adv, pg % 2, adv);
                    run_acc(2'b01, 25'h1ABCD0 + 25'(pg + rd * 16), 16'h0, 2'b11);
                end
        // writes
        for (int wr = 0; wr < 4; wr++)
            for (int wl = 0; wl < 4; wl++)
                for (int bt = 0; bt < 3; bt++) begin
                    set_cfg(0, 0, wr, wl, wl, 0, 0, bt);
                    run_acc((bt == 2) ? 2'b11 : 2'b10, 25'(wr * 4099 + wl * 7 + bt),
                            16'(16'hC001 ^ (wr << 8) ^ (wl << 4) ^ bt), 2'(wl));
                end
        // extreme fields
        set_cfg(15, 15, 15, 15, 15, 15, 15, 15);
        run_acc(2'b00, 25'h1FFFFFF, 16'h0, 2'b01);
        run_acc(2'b01, 25'h0000007, 16'h0, 2'b10);
        run_acc(2'b10, 25'h1555555, 16'hBEEF, 2'b11);
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        run_acc(2'b00, 25'h0, 16'h0, 2'b00);
        run_acc(2'b10, 25'h3, 16'h1234, 2'b10);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule